// File: doc/BRIEF.md
# Frequency-Locked Loop Correction Filter

This block steers a digitally controlled oscillator so that it runs a chosen whole number of times faster than a slow reference clock. A measurement window spans four reference ticks. During the window the filter counts the oscillator's rising edges and compares the total with four times the multiply factor. After each window it moves a period-control word by one step. The step direction follows the sign of the error.

While the error is large, the filter works in coarse mode. Each step then changes the period by one eighth of an octave, so eight steps double or halve it. Once the error is within 15%, the filter raises a stable flag and switches to fine mode. Each fine step changes the period by about a quarter of a percent. A fresh settle starts after reset, after a change of the multiply factor or the trim value, and after the block is re-enabled. The oscillator input is asynchronous and is synchronised into the filter clock.

Top module: `fll_filter`

## Requirements
- R1: After reset the control word is {coarse, fine} with coarse in bits 13:8 and fine in bits 7:0. Coarse holds its mid value 32, fine holds the trim input, and stable and fine_mode are both 0.
- R2: A window is armed by the first ref_tick after a restart and closes on the fourth ref_tick after arming. Oscillator rising edges are counted only inside an armed window. No correction is made before the window closes.
- R3: When a window closes with a count outside the 15% band, the coarse field rises by one if the count exceeds 4·N and falls by one if it is below 4·N.
- R4: A count is inside the band when 100·|count − 4·N| ≤ 15·4·N. Such a window sets stable and fine_mode to 1 and moves the fine field by one in the same direction as R3. A count equal to 4·N leaves both fields unchanged.
- R5: Both fields saturate instead of wrapping: coarse stays within 0..63 and fine stays within 0..255.
- R6: A change of mult_n or trim reloads the state of R1, with fine taken from the new trim, and disarms the window.
- R7: While enable is 0 the stable flag is 0, windows are not counted and the control word holds. Raising enable reloads the state of R1.
- R8: A window outside the band after stable was set clears stable and fine_mode, and the coarse field resumes stepping.
- R9: With an oscillator whose period follows the control word, stable rises and the oscillator frequency settles to within 3% of N times the reference frequency. This also holds after N is changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference period, synchronous to clk |
| osc_tick | input | 1 | Oscillator output, asynchronous square wave |
| mult_n | input | 8 | Multiply factor N |
| trim | input | 8 | Trim value, loaded into the fine field on restart |
| enable | input | 1 | Filter enable; a rising edge restarts settling |
| ctrl_word | output | 14 | Period control: coarse in 13:8, fine in 7:0 |
| stable | output | 1 | Error within 15% at the last closed window |
| fine_mode | output | 1 | 1 when fine steps are in use, 0 for coarse steps |

## Verification
Any corrupted window count or error verdict shows at the ports one cycle after the closing reference tick. It appears as a wrong step on the control word or a wrong stable or mode flag. The bench supplies exact edge counts per window and predicts each step, so the first faulty window is exposed. A bad synchroniser or a bad step direction only shows across many windows in the closed loop. There it appears as a frequency that never reaches the 3% band within the settle budget.

// File: rtl/fll_pkg.sv
package fll_pkg;

    localparam int COARSE_W    = 6;
    localparam int FINE_W      = 8;
    localparam int MULT_W      = 8;
    localparam int CNT_W       = 12;
    localparam int WIN_TICKS   = 4;
    localparam int NEAR_PCT    = 15;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        STEP_HOLD    = 2'd0,
        STEP_LONGER  = 2'd1,
        STEP_SHORTER = 2'd2
    } step_e;

    typedef enum logic {
        MODE_COARSE = 1'b0,
        MODE_FINE   = 1'b1
    } mode_e;

    typedef struct packed {
        step_e step;
        logic  near;
    } verdict_t;

    // Direction and band test without any division
    function automatic verdict_t judge(input int unsigned count, input int unsigned target);
        verdict_t    v;
        int unsigned mag;
        if (count > target) begin
            v.step = STEP_LONGER;
            mag    = count - target;
        end else if (count < target) begin
            v.step = STEP_SHORTER;
            mag    = target - count;
        end else begin
            v.step = STEP_HOLD;
            mag    = 32'd0;
        end
        v.near = (mag * 32'd100) <= (target * 32'(NEAR_PCT));
        return v;
    endfunction

    // One-LSB move with saturation at 0 and at top
    function automatic int unsigned nudge(input int unsigned val, input step_e s,
                                          input int unsigned top);
        case (s)
            STEP_LONGER:  return (val >= top) ? val : val + 32'd1;
            STEP_SHORTER: return (val == 32'd0) ? val : val - 32'd1;
            default:      return val;
        endcase
    endfunction

endpackage

// File: rtl/fll_edge_sync.sv
module fll_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            last <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/fll_window.sv
module fll_window #(
    parameter int CNT_W = 12,
    parameter int TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             enable,
    input  logic             ref_tick,
    input  logic             osc_rise,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    localparam int               TW   = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [TW-1:0]    LAST = TW'(TICKS - 1);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic             armed;
    logic [TW-1:0]    tick_cnt;
    logic [CNT_W-1:0] osc_cnt;
    logic [CNT_W-1:0] osc_next;

    assign osc_next = (osc_rise && osc_cnt != CMAX) ? osc_cnt + 1'b1 : osc_cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !enable) begin
            armed    <= 1'b0;
            tick_cnt <= '0;
            osc_cnt  <= '0;
            done     <= 1'b0;
            count    <= '0;
        end else begin
            done <= 1'b0;
            if (!armed) begin
                armed    <= ref_tick;
                tick_cnt <= '0;
                osc_cnt  <= '0;
            end else if (ref_tick && tick_cnt == LAST) begin
                done     <= 1'b1;
                count    <= osc_next;
                tick_cnt <= '0;
                osc_cnt  <= '0;
            end else begin
                if (ref_tick) tick_cnt <= tick_cnt + 1'b1;
                osc_cnt <= osc_next;
            end
        end
    end
endmodule

// File: rtl/fll_corrector.sv
module fll_corrector
    import fll_pkg::*;
#(
    parameter int CW    = 6,
    parameter int FW    = 8,
    parameter int MW    = 8,
    parameter int CNT_W = 12,
    parameter int TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             enable,
    input  logic [FW-1:0]    trim,
    input  logic [MW-1:0]    mult,
    input  logic             done,
    input  logic [CNT_W-1:0] count,
    output logic [CW-1:0]    coarse,
    output logic [FW-1:0]    fine,
    output logic             stable,
    output mode_e            mode
);
    localparam int unsigned CMID  = 32'd1 << (CW - 1);
    localparam int unsigned CTOP  = (32'd1 << CW) - 32'd1;
    localparam int unsigned FTOP  = (32'd1 << FW) - 32'd1;
    localparam int unsigned TK    = TICKS;

    int unsigned target;
    verdict_t    v;

    always_comb begin
        target = 32'(mult) * TK;
        v      = judge(32'(count), target);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            coarse <= CW'(CMID);
            fine   <= trim;
            stable <= 1'b0;
            mode   <= MODE_COARSE;
        end else if (!enable) begin
            stable <= 1'b0;
        end else if (done) begin
            if (v.near) begin
                stable <= 1'b1;
                mode   <= MODE_FINE;
                fine   <= FW'(nudge(32'(fine), v.step, FTOP));
            end else begin
                stable <= 1'b0;
                mode   <= MODE_COARSE;
                coarse <= CW'(nudge(32'(coarse), v.step, CTOP));
            end
        end
    end
endmodule

// File: rtl/fll_filter.sv
module fll_filter
    import fll_pkg::*;
#(
    parameter int COARSE_BITS   = COARSE_W,
    parameter int FINE_BITS     = FINE_W,
    parameter int MULT_BITS     = MULT_W,
    parameter int COUNT_BITS    = CNT_W,
    parameter int TICKS_PER_WIN = WIN_TICKS,
    parameter int SYNC_DEPTH    = SYNC_STAGES
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             ref_tick,
    input  logic                             osc_tick,
    input  logic [MULT_BITS-1:0]             mult_n,
    input  logic [FINE_BITS-1:0]             trim,
    input  logic                             enable,
    output logic [COARSE_BITS+FINE_BITS-1:0] ctrl_word,
    output logic                             stable,
    output logic                             fine_mode
);
    logic [MULT_BITS-1:0]   mult_q;
    logic [FINE_BITS-1:0]   trim_q;
    logic                   en_q;
    logic                   restart;
    logic                   osc_rise;
    logic                   win_done;
    logic [COUNT_BITS-1:0]  win_count;
    logic [COARSE_BITS-1:0] coarse;
    logic [FINE_BITS-1:0]   fine;
    mode_e                  mode;

    always_ff @(posedge clk) begin
        mult_q <= mult_n;
        trim_q <= trim;
        en_q   <= enable;
    end

    assign restart = !rst && ((mult_n != mult_q) || (trim != trim_q) || (enable && !en_q));

    fll_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (osc_tick),
        .rise     (osc_rise)
    );

    fll_window #(.CNT_W(COUNT_BITS), .TICKS(TICKS_PER_WIN)) u_win (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .enable   (enable),
        .ref_tick (ref_tick),
        .osc_rise (osc_rise),
        .done     (win_done),
        .count    (win_count)
    );

    fll_corrector #(
        .CW(COARSE_BITS), .FW(FINE_BITS), .MW(MULT_BITS),
        .CNT_W(COUNT_BITS), .TICKS(TICKS_PER_WIN)
    ) u_corr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .enable  (enable),
        .trim    (trim),
        .mult    (mult_n),
        .done    (win_done),
        .count   (win_count),
        .coarse  (coarse),
        .fine    (fine),
        .stable  (stable),
        .mode    (mode)
    );

    assign ctrl_word = {coarse, fine};
    assign fine_mode = (mode == MODE_FINE);
endmodule

// File: rtl/fll_checker.sv
module fll_checker #(
    parameter int CW = 6,
    parameter int FW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            enable,
    input logic [FW-1:0]   trim,
    input logic [CW+FW-1:0] ctrl_word,
    input logic            stable,
    input logic            fine_mode,
    input logic            done_w,
    input logic            restart_w
);
    localparam int            WW       = CW + FW;
    localparam logic [WW-1:0] FINE_ONE = WW'(1);
    localparam logic [WW-1:0] CRS_ONE  = WW'(1) << FW;
    localparam logic [WW-1:0] MIDWORD  = WW'(1) << (WW - 1);

    // R3: the control word moves only after a closed window, a restart or reset
    assert_ctrl_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_word) |-> ($past(done_w) || $past(restart_w) || $past(rst)));

    // R5: a correction changes exactly one field by at most one LSB
    assert_single_lsb_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(done_w) && !$past(restart_w)) |->
            (ctrl_word == $past(ctrl_word) ||
             ctrl_word == $past(ctrl_word) + FINE_ONE ||
             ctrl_word == $past(ctrl_word) - FINE_ONE ||
             ctrl_word == $past(ctrl_word) + CRS_ONE ||
             ctrl_word == $past(ctrl_word) - CRS_ONE));

    // R6: a restart reloads the mid coarse value and the trim
    assert_restart_reload_R6: assert property (@(posedge clk) disable iff (rst)
        $past(restart_w) |-> (ctrl_word == (MIDWORD | WW'($past(trim))) && !stable && !fine_mode));

    // R4: stable only rises at the close of a window
    assert_stable_after_window_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(stable) |-> $past(done_w));

    // R7: a disabled filter reports not stable
    assert_disabled_unstable_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !stable);

    // R8: while running, mode and stable agree
    assert_mode_matches_R8: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable)) |-> (stable == fine_mode));
endmodule

bind fll_filter fll_checker #(.CW(COARSE_BITS), .FW(FINE_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .trim      (trim),
    .ctrl_word (ctrl_word),
    .stable    (stable),
    .fine_mode (fine_mode),
    .done_w    (win_done),
    .restart_w (restart)
);

// File: tb/sim_fll_filter.sv
`timescale 1ns/1ps
module sim_fll_filter;
    logic        clk = 1'b0;
    logic        rst;
    logic        ref_tick;
    logic        osc_man;
    logic        osc_mod;
    logic        model_on;
    logic        osc_tick;
    logic [7:0]  mult_n;
    logic [7:0]  trim;
    logic        enable;
    logic [13:0] ctrl_word;
    logic        stable;
    logic        fine_mode;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    int ec, ef, es, em;

    always #10 clk = ~clk;
    assign osc_tick = model_on ? osc_mod : osc_man;

    fll_filter u0 (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .osc_tick(osc_tick),
        .mult_n(mult_n), .trim(trim), .enable(enable),
        .ctrl_word(ctrl_word), .stable(stable), .fine_mode(fine_mode)
    );

    function automatic real model_period(input logic [13:0] cw);
        real c, f;
        c = real'(int'(cw[13:8]));
        f = real'(int'(cw[7:0]));
        return 300.0 * $pow(2.0, (c - 32.0) / 8.0) * (1.0 + (f - 128.0) / 400.0);
    endfunction

    initial begin
        osc_mod = 1'b0;
        forever begin
            if (model_on) begin
                #(model_period(ctrl_word) / 2.0);
                osc_mod = ~osc_mod;
            end else begin
                #10;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " coarse"}, int'(ctrl_word[13:8]), ec);
        chk({tag, " fine"},   int'(ctrl_word[7:0]),  ef);
        chk({tag, " stable"}, int'(stable),          es);
        chk({tag, " mode"},   int'(fine_mode),       em);
    endtask

    task automatic exp_init();
        ec = 32; ef = int'(trim); es = 0; em = 0;
    endtask

    // Expected effect of one closed window (R3, R4, R5, R8)
    task automatic exp_win(input int k);
        int tgt, d, mag;
        tgt = 4 * int'(mult_n);
        d   = k - tgt;
        mag = (d < 0) ? -d : d;
        if (mag * 100 <= 15 * tgt) begin
            es = 1; em = 1;
            if (d > 0 && ef < 255) ef++;
            if (d < 0 && ef > 0)   ef--;
        end else begin
            es = 0; em = 0;
            if (d > 0 && ec < 63) ec++;
            if (d < 0 && ec > 0)  ec--;
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edges(input int k);
        for (int i = 0; i < k; i++) begin
            osc_man = 1'b1; cyc(2);
            osc_man = 1'b0; cyc(2);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ref_tick = 1'b1; cyc(1);
            ref_tick = 1'b0; cyc(1);
        end
    endtask

    task automatic win(input int k);
        edges(k); cyc(5); ticks(4); cyc(3);
        exp_win(k);
    endtask

    task automatic settle(input int n);
        real err, p, t;
        bit  ok;
        mult_n = 8'(n);
        cyc(3);
        ok = 1'b0;
        err = 1.0;
        t = 4000.0 / real'(n);
        for (int w = 0; w < 85 && !ok; w++) begin
            for (int j = 0; j < 4; j++) begin
                ref_tick = 1'b1; cyc(1);
                ref_tick = 1'b0; cyc(199);
            end
            p = model_period(ctrl_word);
            err = (p > t) ? (p - t) / t : (t - p) / t;
            if (stable && err <= 0.03) ok = 1'b1;
        end
        chk("R9 stable after settle", int'(stable), 1);
        total++;
        if (!(err <= 0.03)) begin
            bad++;
            $display("FAIL R9 period actual=%0d ps expected=%0d ps", int'(p * 1000.0), int'(t * 1000.0));
        end
    endtask

    initial begin
        rst = 1'b1; ref_tick = 1'b0; osc_man = 1'b0; model_on = 1'b0;
        mult_n = 8'd20; trim = 8'd128; enable = 1'b1;
        void'($urandom(32'd2024));
        cyc(4);
        rst = 1'b0;
        cyc(2);
        exp_init();
        chk_state("R1 reset");

        // R2: edges before arming ignored, partial window makes no change
        edges(50);
        ticks(1);
        edges(80); cyc(5);
        ticks(3); cyc(3);
        chk_state("R2 open window");
        ticks(1); cyc(3);
        exp_win(80);
        chk_state("R2 closed window");

        win(93); chk_state("R3 longer");
        win(67); chk_state("R3 shorter");
        win(92); chk_state("R4 band edge");
        win(80); chk_state("R4 exact hold");
        win(70); chk_state("R4 fine down");
        win(100); chk_state("R8 falls out");
        win(93); chk_state("R3 coarse again");

        for (int i = 0; i < 30; i++) begin
            win(int'($urandom_range(102, 58)));
            chk_state("R3 R4 R8 random");
        end

        trim = 8'd5; cyc(3); exp_init(); chk_state("R6 trim change");
        trim = 8'd0; cyc(3); exp_init(); chk_state("R6 trim zero");
        ticks(1);
        win(78); chk_state("R5 fine floor");
        trim = 8'd255; cyc(3); exp_init();
        ticks(1);
        win(82); chk_state("R5 fine ceiling");

        mult_n = 8'd1; cyc(3); exp_init(); chk_state("R6 mult change");
        ticks(1);
        for (int i = 0; i < 31; i++) win(10);
        chk_state("R5 coarse reaches top");
        win(10); chk_state("R5 coarse top held");
        for (int i = 0; i < 64; i++) win(0);
        chk_state("R5 coarse bottom held");

        win(4); chk_state("R4 exact at N=1");
        enable = 1'b0; cyc(2); es = 0;
        chk_state("R7 disabled");
        ticks(1); win(10);
        ec = 0; ef = 255; es = 0; em = 1;
        chk_state("R7 held while disabled");
        enable = 1'b1; cyc(2); exp_init();
        chk_state("R7 re-enable");

        trim = 8'd128; cyc(3);
        model_on = 1'b1;
        settle(20);
        settle(12);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R9 actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule